// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides, cycle by cycle, when the gate of a synchronous rectifier switch is driven high and when it is released. It watches two digitised comparator flags derived from the switch's drain-sense voltage, one raised when the voltage has crossed the turn-on level and one raised when it has reached the turn-off level. It also watches an external trigger input that can cut a conduction pulse short. An enable from a separate sleep manager gates the whole sequencer.

Each pulse has two timing windows, both counted in clock cycles from the turn-on edge. In the first few cycles, the blanking window, trigger edges are disregarded, so that switching noise coupled onto the trigger line cannot end the pulse. Sense-based release waits for the longer minimum on-time, and a release request that arrives early is deferred until that time expires. A trigger rising edge that arrives after blanking ends the pulse at once, even inside the minimum on-time. After every release, the turn-on comparator has to drop and then assert again before another pulse may start, so each sense cycle produces at most one pulse.

Top module: `sr_gate_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `gate_drv` is low.
- R2: With `enable` high, the sequencer armed and `trig_in` low, a rise of `sense_on` drives `gate_drv` high on the third rising clock edge after the change. Each comparator and trigger input passes through two synchronizer flops before the one gate register.
- R3: Trigger rising edges that reach the sequencer during the first BLANK_CYC cycles of a pulse are ignored, and `gate_drv` stays high.
- R4: A trigger rising edge after the blanking window drives `gate_drv` low three rising edges after the input change, even before MIN_ON_CYC cycles have passed.
- R5: Once the minimum on-time has elapsed, `sense_off` high together with `trig_in` low drives `gate_drv` low. The same rule governs on and off timing when `trig_in` is held low permanently.
- R6: If `sense_off` is already high at turn-on and the trigger stays low, `gate_drv` stays high for exactly MIN_ON_CYC clock cycles.
- R7: After any release, and after the block is enabled, no new pulse starts until the synchronized `sense_on` has been seen low and then high again.
- R8: `enable` low forces `gate_drv` low on the next rising edge and clears both pulse timers, so the first pulse after re-enabling gets the full blanking window and the full minimum on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| enable | input | 1 | Run permission from the sleep manager (synchronous to clk) |
| sense_on | input | 1 | Asynchronous flag: drain sense has crossed the turn-on threshold |
| sense_off | input | 1 | Asynchronous flag: drain sense has reached the turn-off threshold |
| trig_in | input | 1 | Asynchronous external trigger/disable; its rising edge ends a pulse |
| gate_drv | output | 1 | Gate-drive request, high while the rectifier conducts |

## Verification
The inputs are asynchronous, so every result that comes from `sense_on`, `sense_off` or `trig_in` is due on the third rising edge after the input changes: two synchronizer flops and then the gate register. The one exception is `enable`, whose effect is due on the very next edge. The bench changes inputs only on falling edges and samples `gate_drv` on falling edges. It compares each sample with a cycle model that carries the same three-edge delay, and the directed cases count how many falling-edge samples of a pulse are high, to measure pulse widths against MIN_ON_CYC and BLANK_CYC.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REARM = 2'd1,
    ST_ARMED = 2'd2,
    ST_ON    = 2'd3
  } sr_state_e;

  // counter width wide enough for the longer of the two windows
  function automatic int unsigned cnt_w(input int unsigned min_on, input int unsigned blank);
    int unsigned top;
    top = (min_on > blank) ? min_on : blank;
    return (top < 2) ? 1 : $clog2(top + 1);
  endfunction

  // true while trigger edges must be disregarded (age counts from 0 at turn-on)
  function automatic logic in_blank(input int unsigned age, input int unsigned blank);
    return age < blank;
  endfunction

  // true on the cycle whose closing edge may end a pulse of min_on cycles
  function automatic logic min_met(input int unsigned age, input int unsigned min_on);
    return (age + 1) >= min_on;
  endfunction

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/sr_pulse_timer.sv
module sr_pulse_timer #(
  parameter int unsigned MIN_ON_CYC = 20,
  parameter int unsigned BLANK_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic blank_act,
  output logic min_done
);
  localparam int unsigned CW   = sr_pkg::cnt_w(MIN_ON_CYC, BLANK_CYC);
  localparam int unsigned CMAX = (MIN_ON_CYC > BLANK_CYC) ? MIN_ON_CYC : BLANK_CYC;

  logic [CW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)             age <= '0;
    else if (run && age != CW'(CMAX))  age <= age + 1'b1;
  end

  assign blank_act = sr_pkg::in_blank(int'(age), BLANK_CYC);
  assign min_done  = sr_pkg::min_met(int'(age), MIN_ON_CYC);

  // R3 the blanking window closes before the minimum on-time can end
  blank_before_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && min_done) |-> !blank_act);
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic on_s,
  input  logic off_s,
  input  logic trig_s,
  input  logic blank_act,
  input  logic min_done,
  output logic tmr_restart,
  output logic tmr_run,
  output logic gate
);
  import sr_pkg::*;

  sr_state_e st, st_nx;
  logic trig_d;
  logic trig_rise, turn_on, off_trig, off_sense;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_d <= 1'b0;
    else        trig_d <= trig_s;
  end

  assign trig_rise = trig_s & ~trig_d;
  assign turn_on   = (st == ST_ARMED) && on_s && !trig_s;
  assign off_trig  = (st == ST_ON) && !blank_act && trig_rise;
  assign off_sense = (st == ST_ON) && min_done && off_s && !trig_s;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  st_nx = ST_REARM;
      ST_REARM: if (!on_s) st_nx = ST_ARMED;
      ST_ARMED: if (turn_on) st_nx = ST_ON;
      ST_ON:    if (off_trig || off_sense) st_nx = ST_REARM;
      default:  st_nx = ST_IDLE;
    endcase
    if (!enable) st_nx = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      gate <= 1'b0;
    end else begin
      st   <= st_nx;
      gate <= (st_nx == ST_ON);
    end
  end

  assign tmr_restart = !enable || turn_on;
  assign tmr_run     = (st == ST_ON);

  // R8
  gate_low_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate);
  // R3
  blank_holds_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && enable && blank_act) |=> gate);
  // R6
  min_on_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && enable && !min_done && !off_trig) |=> gate);
  // R4
  trig_cuts_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_trig |=> !gate);
  // R2
  rise_needs_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> ($past(on_s) && !$past(trig_s) && $past(enable)));
  // R7
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |=> !gate);
endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq #(
  parameter int unsigned MIN_ON_CYC  = 20,
  parameter int unsigned BLANK_CYC   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sense_on,
  input  logic sense_off,
  input  logic trig_in,
  output logic gate_drv
);
  localparam int unsigned NIN = 3;

  logic [NIN-1:0] raw_in, syn_in;
  logic blank_act, min_done, tmr_restart, tmr_run;

  assign raw_in = {trig_in, sense_off, sense_on};

  sr_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(syn_in)
  );

  sr_pulse_timer #(.MIN_ON_CYC(MIN_ON_CYC), .BLANK_CYC(BLANK_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart), .run(tmr_run),
    .blank_act(blank_act), .min_done(min_done)
  );

  sr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .on_s(syn_in[0]), .off_s(syn_in[1]), .trig_s(syn_in[2]),
    .blank_act(blank_act), .min_done(min_done),
    .tmr_restart(tmr_restart), .tmr_run(tmr_run), .gate(gate_drv)
  );

  // R1
  reset_gate_low_chk: assert property (@(posedge clk)
    !rst_n |=> !gate_drv);
endmodule

// File: tb/tb_sr_gate_seq.sv
module tb_sr_gate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_ON = 20;
  localparam int BLANK  = 4;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic sense_on = 1'b0, sense_off = 1'b0, trig_in = 1'b0;
  logic gate_drv;

  int n_tests = 0, n_fail = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  sr_gate_seq #(.MIN_ON_CYC(MIN_ON), .BLANK_CYC(BLANK), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sense_on(sense_on),
    .sense_off(sense_off), .trig_in(trig_in), .gate_drv(gate_drv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: pipeline delays of the inputs, then a pulse rule
  bit p_on1, p_on2, p_off1, p_off2, p_t1, p_t2, p_t3;
  int m_phase;   // 0 idle, 1 wait sense low, 2 armed, 3 conducting
  int m_age;
  bit m_gate;

  function automatic bit may_trig_cut(int age, bit rise);
    return rise && (age >= BLANK);
  endfunction
  function automatic bit may_sense_cut(int age, bit off, bit trg);
    return off && !trg && (age + 1 >= MIN_ON);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {p_on1, p_on2, p_off1, p_off2, p_t1, p_t2, p_t3} <= '0;
      m_phase <= 0; m_age <= 0; m_gate <= 0;
    end else begin
      p_on1 <= sense_on;  p_on2 <= p_on1;
      p_off1 <= sense_off; p_off2 <= p_off1;
      p_t1 <= trig_in; p_t2 <= p_t1; p_t3 <= p_t2;
      if (!enable) begin
        m_phase <= 0; m_gate <= 0; m_age <= 0;
      end else begin
        case (m_phase)
          0: m_phase <= 1;
          1: if (!p_on2) m_phase <= 2;
          2: if (p_on2 && !p_t2) begin m_phase <= 3; m_gate <= 1; m_age <= 0; end
          default: begin
            if (may_trig_cut(m_age, p_t2 & ~p_t3) || may_sense_cut(m_age, p_off2, p_t2)) begin
              m_phase <= 1; m_gate <= 0;
            end
            if (m_age < 1000) m_age <= m_age + 1;
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      n_tests++;
      if (gate_drv !== m_gate) begin
        n_fail++;
        $display("FAIL R2 model compare t=%0t: gate_drv=%0b expected %0b", $time, gate_drv, m_gate);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // start a pulse from the armed state; returns when gate first samples high
  task automatic start_pulse(bit off_early);
    sense_on = 1'b0; sense_off = 1'b0; trig_in = 1'b0;
    tick(5);
    sense_on = 1'b1; sense_off = off_early;
    tick(2);
    check("R2 not yet high after two edges", gate_drv, 1'b0);
    tick(1);
    check("R2 high on third edge", gate_drv, 1'b1);
  endtask

  // count high samples until gate drops (the first high sample already seen)
  task automatic measure(output int width);
    width = 1;
    while (gate_drv && width < 200) begin tick(1); if (gate_drv) width++; end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int w;
    void'($urandom(32'd1234));
    tick(3);
    // R1
    check("R1 gate low in reset", gate_drv, 1'b0);
    rst_n = 1'b1;
    tick(1);
    check("R1 gate low after reset release", gate_drv, 1'b0);
    enable = 1'b1;
    tick(2);

    // R6: early sense release held to the minimum on-time
    start_pulse(1'b1);
    measure(w);
    check_int("R6 pulse width with early sense_off", w, MIN_ON);

    // R7: sense_on still high, no second pulse
    sense_off = 1'b0;
    tick(10);
    check("R7 no re-fire without sense_on low", gate_drv, 1'b0);

    // R5: release after minimum on-time when sense_off arrives late
    start_pulse(1'b0);
    tick(MIN_ON + 3);
    check("R5 still on before sense_off", gate_drv, 1'b1);
    sense_off = 1'b1;
    tick(2);
    check("R5 still on two edges after sense_off", gate_drv, 1'b1);
    tick(1);
    check("R5 off on third edge", gate_drv, 1'b0);

    // R3: trigger edge inside blanking ignored
    start_pulse(1'b0);
    trig_in = 1'b1;
    tick(MIN_ON + 5);
    check("R3 trigger in blanking ignored", gate_drv, 1'b1);
    trig_in = 1'b0;
    tick(6);
    // R4: trigger edge after blanking ends it
    trig_in = 1'b1;
    tick(2);
    check("R4 still on two edges after trigger", gate_drv, 1'b1);
    tick(1);
    check("R4 off on third edge", gate_drv, 1'b0);
    trig_in = 1'b0;

    // R4: trigger cuts inside the minimum on-time
    start_pulse(1'b0);
    tick(BLANK + 1);
    trig_in = 1'b1;
    tick(3);
    check("R4 trigger cut inside min on-time", gate_drv, 1'b0);
    trig_in = 1'b0;

    // R8: disable forces low next edge; timers restart after re-enable
    start_pulse(1'b1);
    tick(3);
    enable = 1'b0;
    tick(1);
    check("R8 gate low one edge after disable", gate_drv, 1'b0);
    tick(4);
    enable = 1'b1;
    start_pulse(1'b1);
    measure(w);
    check_int("R8 full minimum on-time after re-enable", w, MIN_ON);

    // R5 and R7 under random stimulus against the model
    sense_on = 0; sense_off = 0; trig_in = 0;
    rst_n = 1'b0; tick(2); rst_n = 1'b1;
    model_on = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 8)  sense_on  = ~sense_on;
      r = int'($urandom % 100);
      if (r < 6)  sense_off = ~sense_off;
      r = int'($urandom % 100);
      if (r < 3)  trig_in   = ~trig_in;
      r = int'($urandom % 1000);
      if (r < 4)  enable    = ~enable;
      else if (!enable && r > 900) enable = 1'b1;
      tick(1);
    end
    model_on = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule